// File: doc/BRIEF.md
# Periodic Idle-Time Memory Scrubber

This block sweeps a configured address window of a memory in the background, one word at a time, so that single-bit soft errors get repaired before a second error lands in the same word. For each address it issues a read on a request port that is shared with the host. It then inspects the ECC verdict that comes back with the read data. When the verdict says the word was corrected, it writes the corrected data straight back to the same address. When the verdict says the word is uncorrectable, it writes nothing and raises a fatal event.

A sweep starts only on a tick of the period timer, so scrubbing happens in bursts rather than continuously. Within a sweep every address from the window's base up to its limit is visited exactly once, in ascending order, whatever the host happens to access. A new read is placed on the port only in a cycle in which the host is not requesting. Once a read has gone out, the step runs to its end. The block raises a hold signal so that the arbiter keeps the host waiting for at most the response and one write-back. If the timer ticks again before a sweep is finished, a sticky overrun flag is set and the sweep carries on. Two saturating counters record corrected and uncorrectable events.

Top module: `mem_scrubber`

## Requirements
- R1: A sweep begins only on a period tick, where a tick happens every `cfg_period` cycles (a value of 0 acts as 1). When a sweep fits inside the period, consecutive `sweep_done` pulses are exactly `cfg_period` cycles apart, and no read is issued between the end of a sweep and the next tick.
- R2: A scrub read (`scrub_req`=1, `scrub_we`=0) is issued only in a cycle where `host_req` is 0.
- R3: Each sweep reads every address from `cfg_base` to `cfg_limit` exactly once, in ascending order, and reads no address outside that window. `sweep_done` pulses for one cycle after the last step.
- R4: A response with `rsp_ecc`=2'b01 (corrected) is followed in the next cycle by exactly one write (`scrub_we`=1) of the returned `rsp_data` to the same address. It also adds one to `corr_count`. A response with `rsp_ecc`=2'b00 (clean) causes no write.
- R5: A response with `rsp_ecc[1]`=1 (2'b10 or 2'b11, uncorrectable) causes no write. It adds one to `fatal_count` and pulses `fatal_evt` for one cycle.
- R6: A period tick that arrives while a sweep is in progress sets `overrun`. The flag stays set until reset, and the sweep continues without restarting.
- R7: From the cycle after a read is accepted until its step ends, `scrub_hold` is 1. With a one-cycle response, the host sees `scrub_hold` for at most 2 consecutive cycles.
- R8: `corr_count` and `fatal_count` stop at their all-ones value instead of wrapping.
- R9: After reset no request or hold is driven, both counters are 0, and `overrun`, `fatal_evt` and `sweep_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | First address of the scrub window |
| cfg_limit | input | AW | Last address of the scrub window (at or above base) |
| cfg_period | input | PW | Sweep period in cycles |
| host_req | input | 1 | Host has a request pending on the shared port |
| rsp_valid | input | 1 | Read response is present |
| rsp_ecc | input | 2 | ECC verdict: 00 clean, 01 corrected, 1x uncorrectable |
| rsp_data | input | DW | Read data after correction |
| scrub_req | output | 1 | Scrub request on the shared port |
| scrub_we | output | 1 | Request is a write-back |
| scrub_addr | output | AW | Request address |
| scrub_wdata | output | DW | Write-back data |
| scrub_hold | output | 1 | A scrub step is in progress; the arbiter holds the host |
| corr_count | output | CW | Saturating count of corrected words |
| fatal_count | output | CW | Saturating count of uncorrectable words |
| fatal_evt | output | 1 | One-cycle pulse per uncorrectable word |
| overrun | output | 1 | Sticky flag: the period ended during a sweep |
| sweep_done | output | 1 | One-cycle pulse after a sweep completes |

## Verification
A read request appears in the same cycle as an idle host cycle, because it is decoded combinationally from the state and `host_req`. The bench's memory model returns the response one clock later. A corrected word's write-back is on the port the cycle after that. The counters, `fatal_evt` and `sweep_done` change on the edge that ends the step, so they are visible in the following cycle. The bench drives `host_req` and the response on the rising edge and samples every output on the falling edge. It logs each request as it appears and checks the counters and flags only at the falling edge where `sweep_done` is high, when every register on the path has settled. Period spacing is measured in simulation time between `sweep_done` pulses.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2,
        ST_WB    = 2'd3
    } scrub_st_e;

    localparam logic [1:0] ECC_CLEAN = 2'b00;
    localparam logic [1:0] ECC_FIXED = 2'b01;
endpackage

// File: rtl/scrub_period_timer.sv
module scrub_period_timer #(
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period,
    output logic          tick
);
    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim   = (period == '0) ? '0 : period - 1'b1;
        tick  = (cnt_q >= lim);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period > 1) |=> !tick);
endmodule

// File: rtl/scrub_sat_cnt.sv
module scrub_sat_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX) |=> (cnt_q == CMAX));
    assert_sat_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber
    import scrub_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 64,
    parameter int PW = 20,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic [PW-1:0] cfg_period,
    input  logic          host_req,
    input  logic          rsp_valid,
    input  logic [1:0]    rsp_ecc,
    input  logic [DW-1:0] rsp_data,
    output logic          scrub_req,
    output logic          scrub_we,
    output logic [AW-1:0] scrub_addr,
    output logic [DW-1:0] scrub_wdata,
    output logic          scrub_hold,
    output logic [CW-1:0] corr_count,
    output logic [CW-1:0] fatal_count,
    output logic          fatal_evt,
    output logic          overrun,
    output logic          sweep_done
);
    localparam int NEVT = 2;   // event 0: corrected, event 1: uncorrectable

    typedef struct packed {
        scrub_st_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          overrun;
        logic          done;
        logic          fatal;
    } scrub_state_t;

    scrub_state_t  r_d, r_q;
    logic          tick;
    logic          step_end;
    logic [NEVT-1:0] evt_inc;
    logic [CW-1:0]   evt_cnt [NEVT];

    scrub_period_timer #(.PW(PW)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (cfg_period),
        .tick   (tick)
    );

    for (genvar g = 0; g < NEVT; g++) begin : g_evt
        scrub_sat_cnt #(.CW(CW)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt_inc[g]),
            .count (evt_cnt[g])
        );
    end

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fatal = 1'b0;
        evt_inc   = '0;
        step_end  = 1'b0;

        if (tick && r_q.st != ST_WAIT) r_d.overrun = 1'b1;

        case (r_q.st)
            ST_WAIT: begin
                if (tick) begin
                    r_d.st   = ST_ISSUE;
                    r_d.addr = cfg_base;
                end
            end
            ST_ISSUE: begin
                if (!host_req) r_d.st = ST_RESP;
            end
            ST_RESP: begin
                if (rsp_valid) begin
                    if (rsp_ecc == ECC_CLEAN) begin
                        step_end = 1'b1;
                    end else if (rsp_ecc == ECC_FIXED) begin
                        evt_inc[0] = 1'b1;
                        r_d.wdata  = rsp_data;
                        r_d.st     = ST_WB;
                    end else begin
                        evt_inc[1] = 1'b1;
                        r_d.fatal  = 1'b1;
                        step_end   = 1'b1;
                    end
                end
            end
            default: begin
                step_end = 1'b1;
            end
        endcase

        if (step_end) begin
            if (r_q.addr == cfg_limit) begin
                r_d.st   = ST_WAIT;
                r_d.done = 1'b1;
            end else begin
                r_d.st   = ST_ISSUE;
                r_d.addr = r_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_WAIT;
            r_q.addr    <= '0;
            r_q.wdata   <= '0;
            r_q.overrun <= 1'b0;
            r_q.done    <= 1'b0;
            r_q.fatal   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scrub_req   = (r_q.st == ST_ISSUE && !host_req) || (r_q.st == ST_WB);
    assign scrub_we    = (r_q.st == ST_WB);
    assign scrub_addr  = r_q.addr;
    assign scrub_wdata = r_q.wdata;
    assign scrub_hold  = (r_q.st == ST_RESP) || (r_q.st == ST_WB);
    assign corr_count  = evt_cnt[0];
    assign fatal_count = evt_cnt[1];
    assign fatal_evt   = r_q.fatal;
    assign overrun     = r_q.overrun;
    assign sweep_done  = r_q.done;

    assert_read_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_req && !scrub_we) |-> !host_req);
    assert_wb_after_fix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_we |-> $past(rsp_valid && rsp_ecc == ECC_FIXED));
    assert_no_fatal_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RESP && rsp_valid && rsp_ecc[1]) |=> (!scrub_we && fatal_evt));
    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_hold_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_we |=> !scrub_hold);
endmodule

// File: tb/mem_scrubber_tb_top.sv
module mem_scrubber_tb_top;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int PW = 8;
    localparam int CW = 4;
    localparam int CMAX = 15;
    localparam int NV = 7;

    // fields: base[29:27] limit[26:24] corr[23:16] fatal[15:8] host[7:0]
    localparam logic [29:0] VEC [NV] = '{
        {3'd0, 3'd7, 8'h00, 8'h00, 8'h00},
        {3'd0, 3'd7, 8'h12, 8'h40, 8'h00},
        {3'd2, 3'd5, 8'hFF, 8'h00, 8'h55},
        {3'd3, 3'd3, 8'h08, 8'h00, 8'hFE},
        {3'd1, 3'd6, 8'hAA, 8'h01, 8'h33},
        {3'd0, 3'd7, 8'hF0, 8'h0F, 8'hCC},
        {3'd0, 3'd7, 8'h03, 8'h00, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_limit = '0;
    logic [PW-1:0] cfg_period = 8'd64;
    logic          host_req = 1'b0;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_ecc = 2'b00;
    logic [DW-1:0] rsp_data = '0;
    logic          scrub_req, scrub_we, scrub_hold, fatal_evt, overrun, sweep_done;
    logic [AW-1:0] scrub_addr;
    logic [DW-1:0] scrub_wdata;
    logic [CW-1:0] corr_count, fatal_count;

    always #10 clk = ~clk;

    mem_scrubber #(.AW(AW), .DW(DW), .PW(PW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_period(cfg_period), .host_req(host_req), .rsp_valid(rsp_valid),
        .rsp_ecc(rsp_ecc), .rsp_data(rsp_data), .scrub_req(scrub_req),
        .scrub_we(scrub_we), .scrub_addr(scrub_addr), .scrub_wdata(scrub_wdata),
        .scrub_hold(scrub_hold), .corr_count(corr_count), .fatal_count(fatal_count),
        .fatal_evt(fatal_evt), .overrun(overrun), .sweep_done(sweep_done)
    );

    logic [7:0] corr_mask = '0, fatal_mask = '0, host_pat = '0;
    logic [2:0] host_ph = '0;

    function automatic logic [DW-1:0] fixed_word(input logic [AW-1:0] a);
        return {4'h5, a, ~a, 4'hA};
    endfunction

    // host traffic and memory model, driven on the rising edge
    always @(posedge clk) begin
        host_ph   <= host_ph + 3'd1;
        host_req  <= rst_n & host_pat[host_ph];
        rsp_valid <= scrub_req & ~scrub_we;
        rsp_data  <= fixed_word(scrub_addr);
        if (scrub_addr[3] == 1'b0 && fatal_mask[scrub_addr[2:0]]) rsp_ecc <= 2'b10;
        else if (scrub_addr[3] == 1'b0 && corr_mask[scrub_addr[2:0]]) rsp_ecc <= 2'b01;
        else rsp_ecc <= 2'b00;
    end

    int reads [16];
    int writes [16];
    int ord_err = 0, wd_err = 0, r2_err = 0, r7_err = 0, stall = 0, fatal_pulses = 0;
    int cycles = 0;
    logic [AW-1:0] exp_next = '0;
    logic [AW-1:0] cur_base = '0;
    int checks = 0, fails = 0;

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (scrub_req && !scrub_we) begin
                if (host_req) r2_err++;
                reads[scrub_addr]++;
                if (scrub_addr != exp_next) ord_err++;
                exp_next = scrub_addr + 1'b1;
            end
            if (scrub_req && scrub_we) begin
                writes[scrub_addr]++;
                if (scrub_wdata != fixed_word(scrub_addr)) wd_err++;
            end
            if (scrub_hold && host_req) stall++; else stall = 0;
            if (stall > 2) r7_err++;
            if (fatal_evt) fatal_pulses++;
            if (sweep_done) exp_next = cur_base;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int a = 0; a < 16; a++) begin
            reads[a]  = 0;
            writes[a] = 0;
        end
        ord_err = 0; wd_err = 0; r2_err = 0; r7_err = 0; fatal_pulses = 0;
    endtask

    task automatic wait_done(output realtime t);
        int n = 0;
        @(negedge clk);
        while (!sweep_done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        t = $realtime;
        chk(sweep_done == 1'b1, "R3 sweep completes", n, 0);
    endtask

    task automatic chk_cover(input int b, input int l, input string tag);
        int bad = 0;
        for (int a = 0; a < 16; a++)
            if (reads[a] != ((a >= b && a <= l) ? 1 : 0)) bad++;
        chk(bad == 0, tag, bad, 0);
        chk(ord_err == 0, "R3 ascending order", ord_err, 0);
    endtask

    initial begin
        realtime t0, t1, t2;
        int exp_corr = 0, exp_fatal = 0;
        clear_logs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!scrub_req && !scrub_hold, "R9 no request after reset", int'(scrub_req), 0);
        chk(corr_count == 0 && fatal_count == 0, "R9 counters zero", int'(corr_count) + int'(fatal_count), 0);
        chk(!overrun && !fatal_evt && !sweep_done, "R9 flags zero", int'(overrun), 0);

        for (int v = 0; v < NV; v++) begin
            int b, l, nc, nf, wbad, fbad;
            b = int'(VEC[v][29:27]);
            l = int'(VEC[v][26:24]);
            cfg_base   = AW'(b);
            cfg_limit  = AW'(l);
            cur_base   = AW'(b);
            exp_next   = AW'(b);
            corr_mask  = VEC[v][23:16];
            fatal_mask = VEC[v][15:8];
            host_pat   = VEC[v][7:0];
            clear_logs();
            wait_done(t0);
            nc = 0; nf = 0; wbad = 0; fbad = 0;
            for (int a = 0; a < 16; a++) begin
                bit inr, isf, isc;
                inr = (a >= b && a <= l);
                isf = inr && fatal_mask[a % 8];
                isc = inr && !isf && corr_mask[a % 8];
                if (isf) nf++;
                if (isc) nc++;
                if (writes[a] != (isc ? 1 : 0)) wbad++;
                if (isf && writes[a] != 0) fbad++;
            end
            exp_corr  = (exp_corr + nc > CMAX) ? CMAX : exp_corr + nc;
            exp_fatal = (exp_fatal + nf > CMAX) ? CMAX : exp_fatal + nf;
            chk_cover(b, l, "R3 each address read once");
            chk(r2_err == 0, "R2 reads only while host idle", r2_err, 0);
            chk(wbad == 0 && wd_err == 0, "R4 write-back of corrected words", wbad + wd_err, 0);
            chk(fbad == 0, "R5 no write to uncorrectable word", fbad, 0);
            chk(int'(corr_count) == exp_corr, "R4/R8 corr_count", int'(corr_count), exp_corr);
            chk(int'(fatal_count) == exp_fatal, "R5 fatal_count", int'(fatal_count), exp_fatal);
            chk(fatal_pulses == nf, "R5 fatal_evt pulses", fatal_pulses, nf);
            chk(r7_err == 0, "R7 host held at most two cycles", r7_err, 0);
            chk(!overrun, "R6 no overrun when sweep fits", int'(overrun), 0);
        end
        // R8: total corrected events exceed the counter range
        chk(int'(corr_count) == CMAX, "R8 corr_count saturated", int'(corr_count), CMAX);

        // R1: period spacing with a fitting sweep
        corr_mask = '0; fatal_mask = '0; host_pat = '0;
        cfg_base = 4'd0; cfg_limit = 4'd7; cur_base = 4'd0; cfg_period = 8'd40;
        wait_done(t0);
        clear_logs();
        exp_next = 4'd0;
        wait_done(t1);
        wait_done(t2);
        chk((t2 - t1) == 40 * 20, "R1 sweeps spaced by period", int'((t2 - t1) / 20), 40);
        for (int a = 0; a < 8; a++)
            chk(reads[a] == 2, "R1 one read per address per period", reads[a], 2);

        // R6: period shorter than the sweep
        cfg_period = 8'd4;
        wait_done(t0);
        clear_logs();
        exp_next = 4'd0;
        wait_done(t1);
        chk(overrun == 1'b1, "R6 overrun set", int'(overrun), 1);
        chk_cover(0, 7, "R6 sweep continues to full coverage");
        cfg_period = 8'd64;
        wait_done(t2);
        chk(overrun == 1'b1, "R6 overrun sticky", int'(overrun), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        while (cycles < 150000) @(negedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule